// File: doc/BRIEF.md
# Machine Trap Entry and Return Sequencer

This block sequences trap entry and trap return for a small hart that has machine and user privilege levels. In each cycle it accepts at most one event: an exception request (cause code, instruction address, instruction word), an interrupt request (cause code and the address of the next sequential instruction), a return request (machine return or user return), or a control-transfer request (jump, register-indirect jump or conditional branch). It can also take a write to its own small set of state registers. It keeps the machine exception PC, the user exception PC, the trap value, the trap cause, the status fields (MIE, MPIE, MPP, UIE, UPIE) and the current privilege level.

Every event that changes the program counter produces a one-cycle redirect strobe together with the new PC. Trap entry always goes to the plain `trap_base` input; vectoring is not part of this block. The trap value is chosen according to the cause. A register that holds fault data supplies the trap value for all causes other than 0 and 2, and trap entry clears it. Control transfers are checked for alignment before they take effect. A return issued from below its own privilege level becomes an illegal-instruction trap.

Top module: `trap_sequencer`

## Requirements
- R1: After a synchronous reset, the following hold: privilege is machine (encoding 2'b11), the status word reads 0x1800 (MPP = machine, all enable bits 0), the machine PC, user PC, trap value and cause all read 0, and `redirect` and `link_we` are low.
- R2: On an exception, the following happen. The machine PC takes `cur_pc` with its low ALIGN_LOG2 bits cleared. The cause takes `exc_cause` with bit XLEN-1 clear. MPIE takes the old MIE and MIE clears. MPP takes the old privilege and privilege becomes machine. `redirect` pulses with `next_pc` = `trap_base`.
- R3: On an interrupt, the machine PC takes `next_pc_in` with its low ALIGN_LOG2 bits cleared. The cause takes `irq_cause` with bit XLEN-1 set. The status fields and privilege change as in R2. The trap value is left unchanged.
- R4: For exception cause 0 (misaligned instruction address), the trap value is `cur_pc`.
- R5: For exception cause 2 (illegal instruction), the trap value is the whole `instr_word` when its bits [1:0] are 2'b11. Otherwise it is `instr_word[15:0]`, zero-extended.
- R6: For every other exception cause, the trap value is the stored fault data, which `fault_set` loads from `fault_value`. Every exception entry clears the stored fault data to 0.
- R7: The block raises exception cause 0 instead of redirecting or writing the link register in two cases: a jump (`xfer_kind` 0) whose `xfer_imm` is not a multiple of 2^ALIGN_LOG2, and a taken branch (`xfer_kind` 2) whose `xfer_imm` is not a multiple of 2^ALIGN_LOG2. A register-indirect jump (`xfer_kind` 1) clears bit 0 of `xfer_base + xfer_imm` before the same check.
- R8: An aligned jump or taken branch redirects to `cur_pc + xfer_imm`. A register-indirect jump redirects to the cleared target. Both kinds of jump with `xfer_link` set raise `link_we` with `link_value` = `cur_pc + 4`. A branch never writes a link. A branch that is not taken produces no redirect and no state change.
- R9: A machine return (`ret_mode` = 1) has these effects. Privilege takes MPP. MPP becomes user (2'b00). MIE takes MPIE and MPIE sets. `next_pc` is the machine PC.
- R10: A user return (`ret_mode` = 0) has these effects. Privilege becomes user. UIE takes UPIE and UPIE sets. `next_pc` is the user PC.
- R11: A return whose level (machine = 3, user = 0) is above the current privilege is taken instead as exception cause 2. The trap value follows R5 from `instr_word`, and no status field is popped.
- R12: State writes (`csr_sel` 0 = machine PC, 1 = user PC, 2 = status) work as follows. PC writes clear the low ALIGN_LOG2 bits. Status writes update only UIE (bit 0), MIE (bit 3), UPIE (bit 4), MPIE (bit 7) and MPP (bits 12:11); an MPP value other than 2'b11 is stored as user.
- R13: When several requests arrive together, the block takes exactly one, in this order: exception, interrupt, return, control transfer, state write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_pc | input | XLEN | Address of the current instruction |
| next_pc_in | input | XLEN | Address of the next sequential instruction, saved on interrupt |
| trap_base | input | XLEN | Trap entry address |
| exc_req | input | 1 | Exception request |
| exc_cause | input | 5 | Exception cause code |
| instr_word | input | 32 | Instruction word of the current instruction |
| fault_set | input | 1 | Load the stored fault data |
| fault_value | input | XLEN | Fault data to store |
| irq_req | input | 1 | Interrupt request |
| irq_cause | input | 5 | Interrupt cause code |
| ret_req | input | 1 | Return request |
| ret_mode | input | 1 | 1 = machine return, 0 = user return |
| xfer_req | input | 1 | Control-transfer request |
| xfer_kind | input | 2 | 0 jump, 1 register-indirect jump, 2 branch |
| xfer_taken | input | 1 | Branch condition outcome |
| xfer_link | input | 1 | Jump writes a nonzero link register |
| xfer_base | input | XLEN | Base register value for the indirect jump |
| xfer_imm | input | XLEN | Sign-extended offset |
| csr_we | input | 1 | State write strobe |
| csr_sel | input | 2 | 0 machine PC, 1 user PC, 2 status |
| csr_wdata | input | XLEN | State write data |
| redirect | output | 1 | One-cycle strobe: `next_pc` is valid |
| next_pc | output | XLEN | New program counter |
| link_we | output | 1 | Link register write strobe |
| link_value | output | XLEN | Link value |
| priv | output | 2 | Current privilege (2'b11 machine, 2'b00 user) |
| mstatus | output | XLEN | Status word |
| mepc | output | XLEN | Machine exception PC |
| uepc | output | XLEN | User exception PC |
| mtval | output | XLEN | Trap value |
| mcause | output | XLEN | Trap cause |

## Verification
Every result of this block sits one register stage behind its request. A request presented before a rising edge shows its `redirect`, `next_pc`, link strobe, privilege and state values right after that edge, and `redirect` and `link_we` fall again one edge later. The bench drives each request on a falling edge, lets exactly one rising edge pass, and compares all outputs on the following falling edge against a field-level model. The model is updated from the requirement text. The bench then drops the request before the next edge, so each strobe is checked in the one cycle it belongs to.

// File: rtl/trap_pkg.sv
package trap_pkg;
    // Privilege encodings (only machine and user exist).
    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_M = 2'b11;

    // Control-transfer kinds.
    localparam logic [1:0] XF_JAL    = 2'd0;
    localparam logic [1:0] XF_JALR   = 2'd1;
    localparam logic [1:0] XF_BRANCH = 2'd2;

    // State write selectors.
    localparam logic [1:0] SEL_MEPC   = 2'd0;
    localparam logic [1:0] SEL_UEPC   = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

    // Status word bit positions.
    localparam int ST_UIE    = 0;
    localparam int ST_MIE    = 3;
    localparam int ST_UPIE   = 4;
    localparam int ST_MPIE   = 7;
    localparam int ST_MPP_LO = 11;
    localparam int ST_MPP_HI = 12;

    // Exception causes with a special trap value.
    localparam logic [4:0] CAUSE_PC_MISALIGN = 5'd0;
    localparam logic [4:0] CAUSE_ILLEGAL     = 5'd2;

    // Action chosen in one cycle.
    localparam logic [2:0] ACT_NONE = 3'd0;
    localparam logic [2:0] ACT_EXC  = 3'd1;
    localparam logic [2:0] ACT_IRQ  = 3'd2;
    localparam logic [2:0] ACT_MRET = 3'd3;
    localparam logic [2:0] ACT_URET = 3'd4;
    localparam logic [2:0] ACT_XFER = 3'd5;
    localparam logic [2:0] ACT_CSR  = 3'd6;
endpackage

// File: rtl/xfer_target_check.sv
// Computes the target of a control transfer and flags misalignment.
// Assumes ALIGN_LOG2 >= 1. The indirect jump clears target bit 0
// before the check; the direct kinds check the offset itself.
module xfer_target_check
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_LOG2 = 1
) (
    input  logic [1:0]      kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] imm,
    output logic [XLEN-1:0] target,
    output logic            misaligned
);
    logic [XLEN-1:0] ind_sum;
    logic [XLEN-1:0] probe;

    // Target selection and the value whose low bits are checked.
    always_comb begin
        ind_sum = base + imm;
        if (kind == XF_JALR) begin
            target = {ind_sum[XLEN-1:1], 1'b0};
            probe  = target;
        end else begin
            target = pc + imm;
            probe  = imm;
        end
        misaligned = |probe[ALIGN_LOG2-1:0];
    end
endmodule

// File: rtl/tval_select.sv
// Chooses the trap value for an exception from its cause code.
// Assumes XLEN >= 32 so an instruction word fits unextended.
module tval_select
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [4:0]      cause,
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] fault,
    output logic [XLEN-1:0] tval
);
    // Cause-dependent trap value, compressed-aware for illegal words.
    always_comb begin
        case (cause)
            CAUSE_PC_MISALIGN: tval = pc;
            CAUSE_ILLEGAL: begin
                if (instr[1:0] == 2'b11) tval = XLEN'(instr);
                else                     tval = XLEN'(instr[15:0]);
            end
            default:           tval = fault;
        endcase
    end
endmodule

// File: rtl/hart_status.sv
// Holds privilege, status fields, exception PCs, trap value, cause and
// the stored fault data. Applies exactly one action per cycle as chosen
// by the sequencer; the action inputs are assumed mutually consistent.
module hart_status
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_LOG2 = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      act,
    input  logic [4:0]      trap_cause,
    input  logic [XLEN-1:0] epc_value,
    input  logic [XLEN-1:0] tval_value,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            fault_set,
    input  logic [XLEN-1:0] fault_value,
    output logic [1:0]      priv_o,
    output logic [XLEN-1:0] status_o,
    output logic [XLEN-1:0] mepc_o,
    output logic [XLEN-1:0] uepc_o,
    output logic [XLEN-1:0] mtval_o,
    output logic [XLEN-1:0] mcause_o,
    output logic [XLEN-1:0] fault_o
);
    localparam logic [XLEN-1:0] PC_MASK = ~XLEN'((1 << ALIGN_LOG2) - 1);

    logic [1:0]      priv_q, mpp_q;
    logic            mie_q, mpie_q, uie_q, upie_q;
    logic [XLEN-1:0] mepc_q, uepc_q, mtval_q, mcause_q, fault_q;
    logic            is_trap;

    assign is_trap = (act == ACT_EXC) || (act == ACT_IRQ);

    // Privilege and status-field stack updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_M;
            mpp_q  <= PRIV_M;
            mie_q  <= 1'b0;
            mpie_q <= 1'b0;
            uie_q  <= 1'b0;
            upie_q <= 1'b0;
        end else begin
            case (act)
                ACT_EXC, ACT_IRQ: begin
                    mpie_q <= mie_q;
                    mie_q  <= 1'b0;
                    mpp_q  <= priv_q;
                    priv_q <= PRIV_M;
                end
                ACT_MRET: begin
                    priv_q <= mpp_q;
                    mpp_q  <= PRIV_U;
                    mie_q  <= mpie_q;
                    mpie_q <= 1'b1;
                end
                ACT_URET: begin
                    priv_q <= PRIV_U;
                    uie_q  <= upie_q;
                    upie_q <= 1'b1;
                end
                ACT_CSR: begin
                    if (csr_sel == SEL_STATUS) begin
                        uie_q  <= csr_wdata[ST_UIE];
                        mie_q  <= csr_wdata[ST_MIE];
                        upie_q <= csr_wdata[ST_UPIE];
                        mpie_q <= csr_wdata[ST_MPIE];
                        mpp_q  <= (csr_wdata[ST_MPP_HI:ST_MPP_LO] == PRIV_M) ? PRIV_M : PRIV_U;
                    end
                end
                default: ;
            endcase
        end
    end

    // Exception PCs, trap value and cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mepc_q   <= '0;
            uepc_q   <= '0;
            mtval_q  <= '0;
            mcause_q <= '0;
        end else begin
            if (is_trap) begin
                mepc_q   <= epc_value & PC_MASK;
                mcause_q <= {(act == ACT_IRQ), {(XLEN-6){1'b0}}, trap_cause};
            end
            if (act == ACT_EXC) mtval_q <= tval_value;
            if (act == ACT_CSR && csr_sel == SEL_MEPC) mepc_q <= csr_wdata & PC_MASK;
            if (act == ACT_CSR && csr_sel == SEL_UEPC) uepc_q <= csr_wdata & PC_MASK;
        end
    end

    // Stored fault data: loaded on request, cleared by every exception.
    always_ff @(posedge clk) begin
        if (!rst_n)               fault_q <= '0;
        else if (act == ACT_EXC)  fault_q <= '0;
        else if (fault_set)       fault_q <= fault_value;
    end

    // Output assembly.
    always_comb begin
        status_o                      = '0;
        status_o[ST_UIE]              = uie_q;
        status_o[ST_MIE]              = mie_q;
        status_o[ST_UPIE]             = upie_q;
        status_o[ST_MPIE]             = mpie_q;
        status_o[ST_MPP_HI:ST_MPP_LO] = mpp_q;
    end
    assign priv_o   = priv_q;
    assign mepc_o   = mepc_q;
    assign uepc_o   = uepc_q;
    assign mtval_o  = mtval_q;
    assign mcause_o = mcause_q;
    assign fault_o  = fault_q;

    assert_trap_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_trap |=> (priv_q == PRIV_M) && !mie_q && (mpie_q == $past(mie_q)) && (mpp_q == $past(priv_q)));

    assert_mret_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_MRET) |=> (priv_q == $past(mpp_q)) && (mie_q == $past(mpie_q)) && mpie_q && (mpp_q == PRIV_U));

    assert_uret_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_URET) |=> (priv_q == PRIV_U) && (uie_q == $past(upie_q)) && upie_q);

    assert_fault_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_EXC) |=> (fault_q == '0));

    assert_epc_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CSR && csr_sel == SEL_MEPC) |=> (mepc_q == ($past(csr_wdata) & PC_MASK)));
endmodule

// File: rtl/trap_sequencer.sv
// Trap entry / return sequencer. Picks one request per cycle
// (exception > interrupt > return > transfer > state write), turns
// misaligned transfers and over-privileged returns into exceptions,
// and registers the redirect, link write and all state outputs.
// Assumes XLEN >= 32 and ALIGN_LOG2 >= 1.
module trap_sequencer
    import trap_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ALIGN_LOG2 = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc_in,
    input  logic [XLEN-1:0] trap_base,
    input  logic            exc_req,
    input  logic [4:0]      exc_cause,
    input  logic [31:0]     instr_word,
    input  logic            fault_set,
    input  logic [XLEN-1:0] fault_value,
    input  logic            irq_req,
    input  logic [4:0]      irq_cause,
    input  logic            ret_req,
    input  logic            ret_mode,
    input  logic            xfer_req,
    input  logic [1:0]      xfer_kind,
    input  logic            xfer_taken,
    input  logic            xfer_link,
    input  logic [XLEN-1:0] xfer_base,
    input  logic [XLEN-1:0] xfer_imm,
    input  logic            csr_we,
    input  logic [1:0]      csr_sel,
    input  logic [XLEN-1:0] csr_wdata,
    output logic            redirect,
    output logic [XLEN-1:0] next_pc,
    output logic            link_we,
    output logic [XLEN-1:0] link_value,
    output logic [1:0]      priv,
    output logic [XLEN-1:0] mstatus,
    output logic [XLEN-1:0] mepc,
    output logic [XLEN-1:0] uepc,
    output logic [XLEN-1:0] mtval,
    output logic [XLEN-1:0] mcause
);
    logic [XLEN-1:0] xf_target, tval_w, fault_w;
    logic            xf_misal, xf_active, ret_illegal;
    logic [1:0]      ret_level;
    logic [2:0]      act;
    logic [4:0]      sel_cause;
    logic            redirect_q, link_we_q;
    logic [XLEN-1:0] next_pc_q, link_value_q;

    xfer_target_check #(.XLEN(XLEN), .ALIGN_LOG2(ALIGN_LOG2)) u_xfer (
        .kind(xfer_kind), .pc(cur_pc), .base(xfer_base), .imm(xfer_imm),
        .target(xf_target), .misaligned(xf_misal)
    );

    tval_select #(.XLEN(XLEN)) u_tval (
        .cause(sel_cause), .pc(cur_pc), .instr(instr_word), .fault(fault_w), .tval(tval_w)
    );

    hart_status #(.XLEN(XLEN), .ALIGN_LOG2(ALIGN_LOG2)) u_status (
        .clk(clk), .rst_n(rst_n), .act(act), .trap_cause(sel_cause),
        .epc_value((act == ACT_IRQ) ? next_pc_in : cur_pc),
        .tval_value(tval_w), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .fault_set(fault_set), .fault_value(fault_value),
        .priv_o(priv), .status_o(mstatus), .mepc_o(mepc), .uepc_o(uepc),
        .mtval_o(mtval), .mcause_o(mcause), .fault_o(fault_w)
    );

    assign ret_level   = ret_mode ? PRIV_M : PRIV_U;
    assign ret_illegal = ret_level > priv;
    assign xf_active   = (xfer_kind != XF_BRANCH) || xfer_taken;

    // Request arbitration and conversion of faulting requests into exceptions.
    always_comb begin
        act       = ACT_NONE;
        sel_cause = exc_cause;
        if (exc_req) begin
            act = ACT_EXC;
        end else if (irq_req) begin
            act       = ACT_IRQ;
            sel_cause = irq_cause;
        end else if (ret_req) begin
            if (ret_illegal) begin
                act       = ACT_EXC;
                sel_cause = CAUSE_ILLEGAL;
            end else begin
                act = ret_mode ? ACT_MRET : ACT_URET;
            end
        end else if (xfer_req) begin
            if (xf_active && xf_misal) begin
                act       = ACT_EXC;
                sel_cause = CAUSE_PC_MISALIGN;
            end else if (xf_active) begin
                act = ACT_XFER;
            end
        end else if (csr_we) begin
            act = ACT_CSR;
        end
    end

    // Registered redirect and link-write outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_q   <= 1'b0;
            next_pc_q    <= '0;
            link_we_q    <= 1'b0;
            link_value_q <= '0;
        end else begin
            redirect_q <= (act != ACT_NONE) && (act != ACT_CSR);
            link_we_q  <= (act == ACT_XFER) && (xfer_kind != XF_BRANCH) && xfer_link;
            case (act)
                ACT_EXC, ACT_IRQ: next_pc_q <= trap_base;
                ACT_MRET:         next_pc_q <= mepc;
                ACT_URET:         next_pc_q <= uepc;
                ACT_XFER:         next_pc_q <= xf_target;
                default:          ;
            endcase
            if (act == ACT_XFER) link_value_q <= cur_pc + XLEN'(4);
        end
    end

    assign redirect   = redirect_q;
    assign next_pc    = next_pc_q;
    assign link_we    = link_we_q;
    assign link_value = link_value_q;

    assert_misalign_no_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !exc_req && !irq_req && !ret_req && xf_active && xf_misal)
        |=> !link_we && redirect && (mcause == '0) && (next_pc == $past(trap_base)));

    assert_bad_ret_trap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !exc_req && !irq_req && ret_illegal)
        |=> (mcause == XLEN'(CAUSE_ILLEGAL)) && (priv == PRIV_M) && redirect);

    assert_exc_first_R13: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |=> (mcause == XLEN'($past(exc_cause))) && !link_we);
endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TRAP_BASE = 32'h0000_0800;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cur_pc, next_pc_in, trap_base, fault_value, xfer_base, xfer_imm, csr_wdata, instr_word;
    logic        exc_req, fault_set, irq_req, ret_req, ret_mode, xfer_req, xfer_taken, xfer_link, csr_we;
    logic [4:0]  exc_cause, irq_cause;
    logic [1:0]  xfer_kind, csr_sel;
    logic        redirect, link_we;
    logic [31:0] next_pc, link_value, mstatus, mepc, uepc, mtval, mcause;
    logic [1:0]  priv;

    int checks = 0;
    int failures = 0;

    // Field-level model of the expected state.
    logic [1:0]  e_priv, e_mpp;
    logic        e_mie, e_mpie, e_uie, e_upie;
    logic [31:0] e_mepc, e_uepc, e_mtval, e_mcause, e_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_sequencer #(.XLEN(32), .ALIGN_LOG2(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .next_pc_in(next_pc_in), .trap_base(trap_base),
        .exc_req(exc_req), .exc_cause(exc_cause), .instr_word(instr_word),
        .fault_set(fault_set), .fault_value(fault_value),
        .irq_req(irq_req), .irq_cause(irq_cause), .ret_req(ret_req), .ret_mode(ret_mode),
        .xfer_req(xfer_req), .xfer_kind(xfer_kind), .xfer_taken(xfer_taken), .xfer_link(xfer_link),
        .xfer_base(xfer_base), .xfer_imm(xfer_imm),
        .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .redirect(redirect), .next_pc(next_pc), .link_we(link_we), .link_value(link_value),
        .priv(priv), .mstatus(mstatus), .mepc(mepc), .uepc(uepc), .mtval(mtval), .mcause(mcause)
    );

    function automatic logic [31:0] st_word();
        logic [31:0] w = '0;
        w[0] = e_uie; w[3] = e_mie; w[4] = e_upie; w[7] = e_mpie; w[12:11] = e_mpp;
        return w;
    endfunction

    function automatic logic [31:0] illegal_tval(input logic [31:0] iw);
        return (iw[1:0] == 2'b11) ? iw : {16'h0, iw[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " priv"},    {30'h0, priv}, {30'h0, e_priv});
        chk({req, " status"},  mstatus, st_word());
        chk({req, " mepc"},    mepc, e_mepc);
        chk({req, " uepc"},    uepc, e_uepc);
        chk({req, " mtval"},   mtval, e_mtval);
        chk({req, " mcause"},  mcause, e_mcause);
    endtask

    task automatic idle();
        exc_req = 0; fault_set = 0; irq_req = 0; ret_req = 0; xfer_req = 0; csr_we = 0;
        exc_cause = 0; irq_cause = 0; ret_mode = 0; xfer_kind = 0; xfer_taken = 0; xfer_link = 0;
        csr_sel = 0; csr_wdata = 0; fault_value = 0; xfer_base = 0; xfer_imm = 0;
        instr_word = 0; cur_pc = 0; next_pc_in = 0;
    endtask

    task automatic enter_model();
        e_mpie = e_mie; e_mie = 0; e_mpp = e_priv; e_priv = 2'b11;
    endtask

    task automatic exc_model(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] iw);
        e_mepc = pc & ~32'h1;
        e_mcause = {27'h0, c};
        if (c == 0)      e_mtval = pc;           // R4
        else if (c == 2) e_mtval = illegal_tval(iw); // R5
        else             e_mtval = e_fault;      // R6
        e_fault = 0;
        enter_model();
    endtask

    task automatic check_trap(input string req);
        chk({req, " redirect"}, {31'h0, redirect}, 32'h1);
        chk({req, " vector"}, next_pc, TRAP_BASE);
        chk({req, " link"}, {31'h0, link_we}, 32'h0);
        chk_state(req);
    endtask

    task automatic do_csr(input logic [1:0] sel, input logic [31:0] d);
        csr_we = 1; csr_sel = sel; csr_wdata = d;
        @(negedge clk); idle();
        if (sel == 0) e_mepc = d & ~32'h1;
        else if (sel == 1) e_uepc = d & ~32'h1;
        else begin
            e_uie = d[0]; e_mie = d[3]; e_upie = d[4]; e_mpie = d[7];
            e_mpp = (d[12:11] == 2'b11) ? 2'b11 : 2'b00;
        end
        chk("R12 no redirect", {31'h0, redirect}, 32'h0);
        chk_state("R12");
    endtask

    task automatic do_fault(input logic [31:0] v);
        fault_set = 1; fault_value = v;
        @(negedge clk); idle();
        e_fault = v;
    endtask

    task automatic do_exc(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] iw);
        exc_req = 1; exc_cause = c; cur_pc = pc; instr_word = iw;
        @(negedge clk); idle();
        exc_model(c, pc, iw);
        check_trap("R2/R4/R5/R6 exception");
    endtask

    task automatic do_irq(input logic [4:0] c, input logic [31:0] npc);
        irq_req = 1; irq_cause = c; next_pc_in = npc; cur_pc = 32'h5555_0000;
        @(negedge clk); idle();
        e_mepc = npc & ~32'h1;
        e_mcause = 32'h8000_0000 | {27'h0, c};
        enter_model();
        check_trap("R3 interrupt");
    endtask

    task automatic do_ret(input logic mode, input logic [31:0] pc, input logic [31:0] iw);
        logic [31:0] exp_pc;
        logic [1:0]  lvl = mode ? 2'b11 : 2'b00;
        ret_req = 1; ret_mode = mode; cur_pc = pc; instr_word = iw;
        @(negedge clk); idle();
        if (lvl > e_priv) begin
            exc_model(5'd2, pc, iw);
            check_trap("R11 illegal return");
        end else begin
            if (mode) begin
                exp_pc = e_mepc; e_priv = e_mpp; e_mpp = 0; e_mie = e_mpie; e_mpie = 1;
            end else begin
                exp_pc = e_uepc; e_priv = 0; e_uie = e_upie; e_upie = 1;
            end
            chk(mode ? "R9 redirect" : "R10 redirect", {31'h0, redirect}, 32'h1);
            chk(mode ? "R9 target" : "R10 target", next_pc, exp_pc);
            chk_state(mode ? "R9" : "R10");
        end
    endtask

    task automatic do_xfer(input logic [1:0] k, input logic tk, input logic lk,
                           input logic [31:0] pc, input logic [31:0] b, input logic [31:0] imm);
        logic        active = (k != 2) || tk;
        logic [31:0] tgt = (k == 1) ? ((b + imm) & ~32'h1) : (pc + imm);
        logic        mis = (k == 1) ? tgt[0] : imm[0];
        xfer_req = 1; xfer_kind = k; xfer_taken = tk; xfer_link = lk;
        cur_pc = pc; xfer_base = b; xfer_imm = imm;
        @(negedge clk); idle();
        if (active && mis) begin
            exc_model(5'd0, pc, 32'h0);
            check_trap("R7 misaligned transfer");
        end else if (active) begin
            chk("R8 redirect", {31'h0, redirect}, 32'h1);
            chk("R8 target", next_pc, tgt);
            chk("R8 link_we", {31'h0, link_we}, {31'h0, lk && (k != 2)});
            if (lk && k != 2) chk("R8 link value", link_value, pc + 4);
            chk_state("R8");
        end else begin
            chk("R8 not taken redirect", {31'h0, redirect}, 32'h0);
            chk("R8 not taken link", {31'h0, link_we}, 32'h0);
            chk_state("R8 not taken");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        trap_base = TRAP_BASE;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        e_priv = 2'b11; e_mpp = 2'b11; e_mie = 0; e_mpie = 0; e_uie = 0; e_upie = 0;
        e_mepc = 0; e_uepc = 0; e_mtval = 0; e_mcause = 0; e_fault = 0;
        // R1 reset state
        chk("R1 redirect", {31'h0, redirect}, 32'h0);
        chk("R1 link", {31'h0, link_we}, 32'h0);
        chk("R1 status", mstatus, 32'h0000_1800);
        chk_state("R1");

        // Exception sweep over causes 0..15 with varied status fields, each followed by a machine return.
        for (int i = 0; i < 16; i++) begin
            logic [31:0] w = '0;
            w[3] = i[0]; w[0] = i[1]; w[4] = i[2]; w[7] = i[3];
            w[12:11] = (i % 3 == 0) ? 2'b11 : 2'b01; // R12 WARL on MPP
            do_csr(2'd2, w);
            if (i[0]) do_fault(32'h0F00 + 32'(i));
            do_exc(5'(i), 32'h100 + 32'(i * 6) + 32'(i & 1), 32'h1234_5670 | 32'(i & 3));
            do_csr(2'd2, (mstatus & ~32'h1880) | ((i % 2 == 1) ? 32'h0 : 32'h1800) | (i[1] ? 32'h80 : 32'h0));
            do_ret(1'b1, 32'h300, 32'h3020_0073);
        end

        // R6: fault data cleared by an exception, next generic cause sees 0.
        do_fault(32'hDEAD_BEEF);
        do_exc(5'd5, 32'h700, 32'h0);
        do_exc(5'd7, 32'h704, 32'h0);

        // R5 low-bit sweep for illegal words.
        for (int j = 0; j < 4; j++) do_exc(5'd2, 32'h800, 32'hCAFE_B0B0 | 32'(j));

        // R3 interrupts with odd next-PC values.
        for (int j = 0; j < 3; j++) do_irq(5'(3 + 4 * j), 32'h9001 + 32'(j * 8));

        // R10/R11: return sequences across privilege levels.
        do_csr(2'd1, 32'h2001);
        do_csr(2'd0, 32'h3003);
        do_csr(2'd2, 32'h0000_0090);      // MPP user, MPIE and UPIE set
        do_ret(1'b1, 32'h400, 32'h3020_0073); // machine return to user
        do_ret(1'b0, 32'h404, 32'h0020_0073); // user return from user
        do_ret(1'b1, 32'h408, 32'h0000_3002); // illegal: compressed-looking word
        do_csr(2'd2, 32'h0);
        do_ret(1'b1, 32'h40C, 32'h3020_0073); // back to user
        do_ret(1'b1, 32'h410, 32'h3020_0073); // illegal: full word
        do_ret(1'b0, 32'h414, 32'h0020_0073); // user return from machine is legal

        // R7/R8 control-transfer sweep.
        for (int k = 0; k < 3; k++)
            for (int t = 0; t < 2; t++)
                for (int l = 0; l < 2; l++)
                    for (int m = -5; m <= 5; m++)
                        do_xfer(2'(k), t[0], l[0], 32'h4000 + 32'(k * 64), 32'h9001 + 32'(t), 32'(m));

        // R13 priority: all requests together, exception wins.
        exc_req = 1; exc_cause = 5'd11; irq_req = 1; irq_cause = 5'd7; ret_req = 1; ret_mode = 1;
        xfer_req = 1; xfer_kind = 0; xfer_link = 1; xfer_imm = 32'h10; csr_we = 1; csr_sel = 0;
        csr_wdata = 32'hFFFF_FFFF; cur_pc = 32'hA00; instr_word = 32'h13;
        @(negedge clk); idle();
        exc_model(5'd11, 32'hA00, 32'h13);
        check_trap("R13 exception first");
        // Interrupt over return and transfer.
        irq_req = 1; irq_cause = 5'd3; next_pc_in = 32'hB04; ret_req = 1; ret_mode = 1;
        xfer_req = 1; xfer_kind = 0; xfer_link = 1; xfer_imm = 32'h10; cur_pc = 32'hB00;
        @(negedge clk); idle();
        e_mepc = 32'hB04; e_mcause = 32'h8000_0003; enter_model();
        check_trap("R13 interrupt second");
        // Return over transfer.
        ret_req = 1; ret_mode = 1; xfer_req = 1; xfer_kind = 0; xfer_link = 1; xfer_imm = 32'h10; cur_pc = 32'hC00;
        @(negedge clk); idle();
        chk("R13 return over transfer", next_pc, e_mepc);
        chk("R13 no link", {31'h0, link_we}, 32'h0);
        e_priv = e_mpp; e_mpp = 0; e_mie = e_mpie; e_mpie = 1;
        chk_state("R13 return");
        // Transfer over state write.
        xfer_req = 1; xfer_kind = 0; xfer_imm = 32'h20; cur_pc = 32'hD00; csr_we = 1; csr_sel = 0; csr_wdata = 32'h1234;
        @(negedge clk); idle();
        chk("R13 transfer over write", next_pc, 32'hD20);
        chk_state("R13 transfer");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule